// File: doc/BRIEF.md
# Receive FIFO with error status

This block is the receive buffer of one serial channel. Each received character is stored together with its own three error flags: framing/CRC, overrun and parity. A processor read takes the oldest entry, presents its byte on the read-data output and copies its error flags into an error status byte. The remaining bits of that status byte come from a separate input and pass through unchanged.

An entry that carries any error is not removed when it is read. Instead it raises a special-condition interrupt and holds the buffer on that entry until an error-reset pulse discards it. When the buffer is full, a new character is not dropped. It replaces the newest entry, and that entry's overrun flag is set.

A receive-interrupt mode field selects one of three behaviours: no receive interrupts, one interrupt on the first character after arming, or one interrupt per character. A character-available flag tells the processor that data is waiting.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset the buffer is empty. The character-available flag is 0, read data is 0, the status error bits are 0, both interrupt outputs are 0, and first-character mode is armed.
- R2: Characters are read in arrival order, and at most DEPTH characters are held. A read with `rd_i` high and an error-free head entry removes that entry and shows its byte on `rd_data_o` from the next clock on.
- R3: A character that arrives while DEPTH entries are held and no entry leaves in the same cycle replaces the newest entry's byte. That entry's flags become the incoming framing and parity flags with overrun set, and the entry count is unchanged.
- R4: A character that arrives while the buffer is not full is appended with its overrun flag clear and its incoming framing and parity flags.
- R5: `char_avail_o` is 1 from the clock after any arrival, and is 0 exactly when no entries are held.
- R6: `rx_irq_o` pulses for one cycle, the cycle after an arrival. Mode 2'b00 gives no pulse. Mode 2'b01 pulses only for the first arrival after arming (by reset or `rx_arm_i`). Modes 2'b10 and 2'b11 pulse for every arrival.
- R7: After a read, `err_stat_o` bit 6 is the entry's framing flag, bit 5 its overrun flag and bit 4 its parity flag. All other bits equal `stat_misc_i`.
- R8: Reading an entry with any error flag set pulses `spec_irq_o` the next cycle and leaves the entry in place. Further reads return the same byte and flags and pulse again.
- R9: `err_reset_i` while the buffer is held on an errored entry removes that entry, clears the status error bits and releases the hold. At any other time it has no effect.
- R10: A read of an empty buffer changes neither the read data nor the status error bits, and raises no interrupt.
- R11: When a read removes an entry from a full buffer in the same cycle that a character arrives, the new character is appended normally with overrun clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received-character strobe |
| rx_data_i | input | DATA_W | Received character |
| rx_frame_err_i | input | 1 | Framing/CRC error of the received character |
| rx_par_err_i | input | 1 | Parity error of the received character |
| rx_irq_mode_i | input | 2 | Receive interrupt mode |
| rx_arm_i | input | 1 | Arm first-character interrupt |
| rd_i | input | 1 | Processor data read strobe |
| err_reset_i | input | 1 | Error reset pulse |
| stat_misc_i | input | 8 | Non-error bits of the status byte |
| rd_data_o | output | DATA_W | Last read character |
| err_stat_o | output | 8 | Error status byte |
| char_avail_o | output | 1 | Character available |
| rx_irq_o | output | 1 | Receive interrupt pulse |
| spec_irq_o | output | 1 | Special-condition interrupt pulse |

## Verification
The bench builds the block at its default depth of 3 entries. Because this depth is not a power of two, both pointers wrap through a non-binary boundary within a few characters. A full buffer is also reached after only three arrivals, so overwrite-with-overrun, the read-plus-arrival case at full, and the error hold and its release all come up in short directed sequences and often during a long pseudo-random run. Every cycle, a queue-based model compares all five outputs.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;
  localparam int ERR_W        = 3;
  localparam int STAT_ERR_LSB = 4;  // status bits 6:4 = frame, overrun, parity

  typedef struct packed {
    logic frame;
    logic ovr;
    logic par;
  } rx_err_t;

  typedef enum logic [1:0] {
    IRQ_OFF   = 2'b00,
    IRQ_FIRST = 2'b01,
    IRQ_ALL   = 2'b10,
    IRQ_ALL2  = 2'b11
  } rx_irq_mode_e;
endpackage

// File: rtl/rxf_store.sv
`timescale 1ns/1ps
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DEPTH  = 3,
  parameter int DATA_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       wframe_i,
  input  logic                       wpar_i,
  input  logic                       step_i,
  output logic [DATA_W-1:0]          head_data_o,
  output rx_err_t                    head_err_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] data_q [DEPTH];
  rx_err_t           err_q  [DEPTH];
  logic [PTR_W-1:0]  wp_q, rp_q, newest;
  logic [CNT_W-1:0]  count_q, count_d;
  logic              full_hit;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
  endfunction

  // full only if nothing leaves in the same cycle
  assign full_hit = push_i && (count_q == CNT_W'(DEPTH)) && !step_i;
  assign newest   = ptr_dec(wp_q);

  always_comb begin
    count_d = count_q;
    if (push_i && !full_hit) count_d = count_d + 1'b1;
    if (step_i)              count_d = count_d - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q    <= '0;
      rp_q    <= '0;
      count_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        data_q[i] <= '0;
        err_q[i]  <= '0;
      end
    end else begin
      if (push_i) begin
        if (full_hit) begin
          data_q[newest] <= wdata_i;
          err_q[newest]  <= '{frame: wframe_i, ovr: 1'b1, par: wpar_i};
        end else begin
          data_q[wp_q] <= wdata_i;
          err_q[wp_q]  <= '{frame: wframe_i, ovr: 1'b0, par: wpar_i};
          wp_q         <= ptr_inc(wp_q);
        end
      end
      if (step_i) rp_q <= ptr_inc(rp_q);
      count_q <= count_d;
    end
  end

  assign head_data_o = data_q[rp_q];
  assign head_err_o  = err_q[rp_q];
  assign count_o     = count_q;

  assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  assert_no_underflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (count_q != '0));
  assert_full_keeps_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_hit |=> (count_q == $past(count_q)));
  assert_overrun_marked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_hit |=> err_q[$past(newest)].ovr);
endmodule

// File: rtl/rxf_irq.sv
`timescale 1ns/1ps
module rxf_irq
  import rxf_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  rx_irq_mode_e mode_i,
  input  logic         arm_i,
  output logic         irq_o
);
  logic armed_q, irq_q, fire;

  always_comb begin
    unique case (mode_i)
      IRQ_FIRST:         fire = push_i && armed_q;
      IRQ_ALL, IRQ_ALL2: fire = push_i;
      default:           fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= fire;
      if (arm_i)                                          armed_q <= 1'b1;
      else if (push_i && (mode_i == IRQ_FIRST) && armed_q) armed_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;

  assert_off_silent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && mode_i == IRQ_OFF) |=> !irq_o);
  assert_irq_needs_push_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_i |=> !irq_o);
endmodule

// File: rtl/rx_err_fifo.sv
`timescale 1ns/1ps
module rx_err_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_frame_err_i,
  input  logic              rx_par_err_i,
  input  logic [1:0]        rx_irq_mode_i,
  input  logic              rx_arm_i,
  input  logic              rd_i,
  input  logic              err_reset_i,
  input  logic [7:0]        stat_misc_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [7:0]        err_stat_o,
  output logic              char_avail_o,
  output logic              rx_irq_o,
  output logic              spec_irq_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] head_data;
  rx_err_t           head_err, err_q;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] rd_data_q;
  logic              locked_q, spec_q, char_q;
  logic              head_bad, release_hold, rd_ok, step;

  assign head_bad     = |head_err;
  assign release_hold = err_reset_i && locked_q;
  assign rd_ok        = rd_i && (count != '0) && !release_hold;  // release wins
  assign step         = release_hold || (rd_ok && !head_bad);

  rxf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (rx_valid_i),
    .wdata_i     (rx_data_i),
    .wframe_i    (rx_frame_err_i),
    .wpar_i      (rx_par_err_i),
    .step_i      (step),
    .head_data_o (head_data),
    .head_err_o  (head_err),
    .count_o     (count)
  );

  rxf_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (rx_valid_i),
    .mode_i (rx_irq_mode_e'(rx_irq_mode_i)),
    .arm_i  (rx_arm_i),
    .irq_o  (rx_irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q <= '0;
      err_q     <= '0;
      locked_q  <= 1'b0;
      spec_q    <= 1'b0;
      char_q    <= 1'b0;
    end else begin
      spec_q <= rd_ok && head_bad;
      if (release_hold) begin
        err_q    <= '0;
        locked_q <= 1'b0;
      end else if (rd_ok) begin
        rd_data_q <= head_data;
        err_q     <= head_err;
        if (head_bad) locked_q <= 1'b1;
      end
      if (rx_valid_i)                    char_q <= 1'b1;
      else if (step && count == CNT_W'(1)) char_q <= 1'b0;
    end
  end

  always_comb begin
    err_stat_o = stat_misc_i;
    err_stat_o[STAT_ERR_LSB +: ERR_W] = err_q;
  end

  assign rd_data_o    = rd_data_q;
  assign char_avail_o = char_q;
  assign spec_irq_o   = spec_q;

  assert_char_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_avail_o == (count != '0));
  assert_hold_on_bad_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |-> head_bad);
  assert_spec_has_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec_irq_o |-> (err_stat_o[STAT_ERR_LSB +: ERR_W] != '0));
  assert_release_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_hold |=> (err_stat_o[STAT_ERR_LSB +: ERR_W] == '0) && !spec_irq_o);
  assert_empty_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && count == '0 && !err_reset_i) |=> $stable(rd_data_o) && !spec_irq_o);
endmodule

// File: tb/rx_err_fifo_tb_top.sv
`timescale 1ns/1ps
module rx_err_fifo_tb_top;
  localparam int DEPTH = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push = 0, fr = 0, par = 0, arm = 0, rd = 0, er = 0;
  logic [7:0] data = 0, misc = 0;
  logic [1:0] mode = 0;
  logic [7:0] rd_data_o, err_stat_o;
  logic       char_avail_o, rx_irq_o, spec_irq_o;

  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;
  string ph = "R1";

  always #2.5 clk = ~clk;

  rx_err_fifo #(.DEPTH(DEPTH), .DATA_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(push), .rx_data_i(data),
    .rx_frame_err_i(fr), .rx_par_err_i(par), .rx_irq_mode_i(mode),
    .rx_arm_i(arm), .rd_i(rd), .err_reset_i(er), .stat_misc_i(misc),
    .rd_data_o(rd_data_o), .err_stat_o(err_stat_o), .char_avail_o(char_avail_o),
    .rx_irq_o(rx_irq_o), .spec_irq_o(spec_irq_o));

  // reference model
  logic [7:0] qd[$];
  logic [2:0] qe[$];  // {frame, overrun, parity}
  bit         locked, armed, exp_rxi, exp_spec;
  logic [7:0] exp_rd;
  logic [2:0] exp_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qd.delete(); qe.delete();
      locked = 0; armed = 1; exp_rxi = 0; exp_spec = 0; exp_rd = 0; exp_err = 0;
    end else begin
      exp_rxi = 0; exp_spec = 0;
      if (er && locked) begin
        void'(qd.pop_front()); void'(qe.pop_front());
        exp_err = 0; locked = 0;
      end else if (rd && qd.size() > 0) begin
        exp_rd = qd[0]; exp_err = qe[0];
        if (qe[0] != 0) begin exp_spec = 1; locked = 1; end
        else begin void'(qd.pop_front()); void'(qe.pop_front()); end
      end
      if (push) begin
        if (qd.size() == DEPTH) begin
          qd[DEPTH-1] = data; qe[DEPTH-1] = {fr, 1'b1, par};
        end else begin
          qd.push_back(data); qe.push_back({fr, 1'b0, par});
        end
        if (mode == 2'b01 && armed) begin exp_rxi = 1; armed = 0; end
        else if (mode[1]) exp_rxi = 1;
      end
      if (arm) armed = 1;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (phase %s) t=%0t act %h exp %h", tag, ph, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R2 rd_data", rd_data_o, exp_rd);
      chk("R7 err_stat", err_stat_o, {misc[7], exp_err, misc[3:0]});
      chk("R5 char_avail", {7'b0, char_avail_o}, {7'b0, qd.size() != 0});
      chk("R6 rx_irq", {7'b0, rx_irq_o}, {7'b0, exp_rxi});
      chk("R8 spec_irq", {7'b0, spec_irq_o}, {7'b0, exp_spec});
    end
  end

  task automatic cyc(bit p = 0, logic [7:0] d = 0, bit f = 0, bit pa = 0,
                     bit r = 0, bit e = 0, bit a = 0);
    push = p; data = d; fr = f; par = pa; rd = r; er = e; arm = a;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired in phase %s", ph);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    ph = "R1"; cyc(); cyc();
    // R2 order, mode all
    ph = "R2"; mode = 2'b10; misc = 8'h8f;
    cyc(1, 8'h11); cyc(1, 8'h22); cyc(1, 8'h33); cyc();
    cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 1); cyc();
    // R10 empty reads
    ph = "R10"; cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 1); cyc();
    // R3 overwrite when full
    ph = "R3"; mode = 2'b00; misc = 8'h05;
    cyc(1, 8'hA1); cyc(1, 8'hA2); cyc(1, 8'hA3); cyc(1, 8'hA4, 0, 1); cyc();
    cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 1);
    ph = "R8"; cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 1);
    ph = "R9"; cyc(0, 0, 0, 0, 0, 1); cyc();
    // R4 per-entry flags, R9 reset with no hold
    ph = "R4"; misc = 8'hff;
    cyc(1, 8'h41, 0, 1); cyc(1, 8'h42, 1, 0); cyc(1, 8'h43);
    ph = "R9"; cyc(0, 0, 0, 0, 0, 1); cyc();
    ph = "R4"; cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 1); cyc();
    // R6 first-character mode
    ph = "R6"; mode = 2'b01;
    cyc(0, 0, 0, 0, 0, 0, 1); cyc(1, 8'h61); cyc(1, 8'h62); cyc();
    cyc(0, 0, 0, 0, 0, 0, 1); cyc(1, 8'h63); cyc();
    mode = 2'b11; cyc(0, 0, 0, 0, 1); cyc(1, 8'h64); cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 1); cyc();
    // R11 read and arrival together at full
    ph = "R11"; mode = 2'b00;
    cyc(1, 8'hB1); cyc(1, 8'hB2); cyc(1, 8'hB3); cyc(1, 8'hB4, 0, 0, 1);
    cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 1); cyc();
    // mixed pseudo-random traffic
    ph = "R7";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      bit e;
      r = $urandom;
      if (i % 200 == 0) mode = r[25:24];
      misc = r[31:24];
      e = (r[6:4] == 0);
      cyc(r[0] | r[1], r[23:16], r[12:10] == 0, r[15:13] == 0,
          !e && r[2] && r[3], e, r[9:7] == 0);
    end
    cyc(); cyc();
    finish_run();
  end
endmodule